// File: doc/BRIEF.md
# Programmable Prescaled Down-Counter Timer

This block is a memory-mapped timer built around a decrementing counter. Software reaches it over a simple synchronous register port: select, write strobe, word address, write data and combinational read data. A separate timer clock-enable input sets the rate. A prescaler passes every enable pulse, one in 16 or one in 256 to the counter. The counter is 16 or 32 bits wide and runs in free-running, periodic or one-shot mode.

When the counter steps from 1 to 0, a raw interrupt flag is set. The flag, masked by an enable bit, drives the interrupt output. The load value can be written in two ways. One write restarts the count at once. The other write only changes the value used at the next periodic reload.

Top module: `tmr_down_counter`

## Requirements
- R1: After reset, control reads 0x20 (interrupt enable only, timer stopped), the load and value registers read 0, both interrupt status registers read 0 and `irq` is low.
- R2: Word offsets are: 0 load, 1 value, 2 control, 3 interrupt clear, 4 raw status, 5 masked status, 6 background load. Reads of offset 7 return 0. Writes to offsets 1 and 7 change no register.
- R3: A write to offset 0 stores the limit and sets the counter to the written value in the same cycle. A write to offset 6 stores the limit and leaves the count unchanged. Both offsets read back the stored limit.
- R4: The counter steps down by one only on a counting tick. A counting tick needs `tick_en` high, control bit 7 (run) set and a prescaler output.
- R5: Control bits 3:2 select the prescale ratio. Code 00 counts on every `tick_en` pulse, 01 on every 16th pulse and 10 on every 256th pulse. Code 11 behaves like 00.
- R6: A counting tick that takes the count from 1 to 0 sets the raw flag on the same edge as the count reaches 0. With control bit 6 (periodic) set, the next counting tick reloads the stored limit.
- R7: With bit 6 clear (free-running), a counting tick at 0 reloads 0xFFFF when control bit 1 (size) is 0, and 0xFFFFFFFF when bit 1 is 1.
- R8: With bit 1 clear, only the low 16 bits count and are tested for expiry. The value register reads them zero-extended.
- R9: With control bit 0 (one-shot) set, the counter stays at 0 after it expires until offset 0 is written.
- R10: `irq` and the masked status read both equal the raw flag ANDed with control bit 5. The masked status reads 0 while bit 5 is clear.
- R11: Any write to offset 3 clears the raw flag. If an expiry falls in the same cycle, the flag ends up set.
- R12: Each control write restarts the prescaler phase. After the write, the first count under /16 needs 16 pulses and under /256 needs 256 pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Register access select |
| wr | input | 1 | 1 = write, 0 = read (with `sel`) |
| addr | input | ADDR_W (3) | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational, 0 when not reading |
| tick_en | input | 1 | Timer clock enable |
| irq | output | 1 | Masked interrupt |

## Verification
Reads are combinational from registered state. The bench drives the address on a falling edge and samples one nanosecond later, before any rising edge. A write or a counting tick changes state on the next rising edge, and the results are read on the falling edge after it. Tick bursts hold `tick_en` high across exactly N rising edges, so each expected count is the start value minus N under /1. Prescaled runs expect no change after 15 or 255 pulses and one step on the next pulse. The same-cycle clear/expiry case puts both on a single edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned OFS_W = 3;
  localparam int unsigned CTRL_W = 8;

  typedef enum logic [OFS_W-1:0] {
    OFS_LOAD   = 3'd0,
    OFS_VALUE  = 3'd1,
    OFS_CTRL   = 3'd2,
    OFS_ICLR   = 3'd3,
    OFS_RAW    = 3'd4,
    OFS_MASKED = 3'd5,
    OFS_BGLOAD = 3'd6,
    OFS_SPARE  = 3'd7
  } ofs_e;

  // bit 7 down to bit 0
  typedef struct packed {
    logic       run;
    logic       periodic;
    logic       ie;
    logic       spare;
    logic [1:0] psel;
    logic       wide;
    logic       once;
  } ctrl_t;

  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h20;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned DIV_A_LOG = 4,
  parameter int unsigned DIV_B_LOG = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       run,
  input  logic [1:0] psel,
  input  logic       restart,
  output logic       step
);
  localparam int unsigned PH_W = DIV_B_LOG;

  logic [PH_W-1:0] phase_q, phase_d;
  logic            wrap_a, wrap_b, pulse;

  assign pulse  = tick_en & run;
  assign wrap_a = &phase_q[DIV_A_LOG-1:0];
  assign wrap_b = &phase_q;

  always_comb begin
    case (psel)
      2'b01:   step = pulse & wrap_a;
      2'b10:   step = pulse & wrap_b;
      default: step = pulse;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    if (restart)    phase_d = '0;
    else if (pulse) phase_d = phase_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  // R12: a control write restarts the phase
  a_r12_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase_q == '0));

  // R4: without a pulse the phase holds
  a_r4_phase_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse && !restart) |=> $stable(phase_q));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              load_wr,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] limit,
  input  logic              periodic,
  input  logic              wide,
  input  logic              once,
  output logic [DATA_W-1:0] count_rd,
  output logic              expire
);
  localparam int unsigned PAD_W = DATA_W - NARROW_W;
  localparam logic [DATA_W-1:0] FREE_NARROW = {{PAD_W{1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [DATA_W-1:0] FREE_WIDE   = '1;

  logic [DATA_W-1:0] cnt_q, cnt_d, active, reload_val;
  logic              at_zero, at_one;

  assign active     = wide ? cnt_q : {{PAD_W{1'b0}}, cnt_q[NARROW_W-1:0]};
  assign at_zero    = (active == '0);
  assign at_one     = (active == DATA_W'(1));
  assign reload_val = periodic ? limit : (wide ? FREE_WIDE : FREE_NARROW);
  assign count_rd   = active;

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (load_wr) begin
      cnt_d = load_val;
    end else if (step) begin
      if (at_zero) begin
        if (!once) cnt_d = reload_val;
      end else begin
        cnt_d  = active - DATA_W'(1);
        expire = at_one;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: load write lands on the next edge
  a_r3_load_now: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> (cnt_q == $past(load_val)));

  // R4: no counting tick, no change
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load_wr) |=> $stable(cnt_q));

  // R6: expiry leaves the counter at zero
  a_r6_expire_zero: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == '0));

  // R9: one-shot parks at zero
  a_r9_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (once && at_zero && !load_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  input  logic [DATA_W-1:0] count_rd,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] limit,
  output logic              load_wr,
  output logic              ctrl_wr,
  output logic              raw,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned FLAG_PAD = DATA_W - 1;
  localparam int unsigned CTRL_PAD = DATA_W - CTRL_W;

  ctrl_t             ctrl_q, ctrl_d;
  logic [DATA_W-1:0] limit_q, limit_d, rd_mux;
  logic              raw_q, raw_d, masked;
  logic              in_space, wr_hit, rd_hit, bg_wr, clr_wr;
  ofs_e              ofs;

  assign in_space = ((addr >> OFS_W) == '0);
  assign ofs      = ofs_e'(addr[OFS_W-1:0]);
  assign wr_hit   = sel & wr & in_space;
  assign rd_hit   = sel & ~wr & in_space;
  assign load_wr  = wr_hit && (ofs == OFS_LOAD);
  assign bg_wr    = wr_hit && (ofs == OFS_BGLOAD);
  assign ctrl_wr  = wr_hit && (ofs == OFS_CTRL);
  assign clr_wr   = wr_hit && (ofs == OFS_ICLR);
  assign masked   = raw_q & ctrl_q.ie;

  always_comb begin
    limit_d = limit_q;
    if (load_wr || bg_wr) limit_d = wdata;
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
    raw_d = raw_q;
    if (expire)      raw_d = 1'b1;
    else if (clr_wr) raw_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= ctrl_t'(CTRL_RESET);
      limit_q <= '0;
      raw_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      limit_q <= limit_d;
      raw_q   <= raw_d;
    end
  end

  always_comb begin
    case (ofs)
      OFS_LOAD, OFS_BGLOAD: rd_mux = limit_q;
      OFS_VALUE:            rd_mux = count_rd;
      OFS_CTRL:             rd_mux = {{CTRL_PAD{1'b0}}, ctrl_q};
      OFS_RAW:              rd_mux = {{FLAG_PAD{1'b0}}, raw_q};
      OFS_MASKED:           rd_mux = {{FLAG_PAD{1'b0}}, masked};
      default:              rd_mux = '0;
    endcase
  end

  assign rdata = rd_hit ? rd_mux : '0;
  assign ctrl  = ctrl_q;
  assign limit = limit_q;
  assign raw   = raw_q;

  // R11: expiry wins over a same-cycle clear
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> raw_q);

  // R11: clear without expiry drops the flag
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !expire) |=> !raw_q);

  // R2: control only changes on its own offset
  a_r2_ctrl_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl_q));

  // R3: background load leaves limit equal to the written data
  a_r3_bg_store: assert property (@(posedge clk) disable iff (!rst_n)
    bg_wr |=> (limit_q == $past(wdata)));

  // R10: masked status is silent while the enable is clear
  a_r10_mis_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && ofs == OFS_MASKED && !ctrl_q.ie) |-> (rdata == '0));
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NARROW_W  = 16,
  parameter int unsigned DIV_A_LOG = 4,
  parameter int unsigned DIV_B_LOG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              tick_en,
  output logic              irq
);
  logic              rst_meta, rst_sync;
  ctrl_t             ctrl;
  logic [DATA_W-1:0] limit, count_rd;
  logic              load_wr, ctrl_wr, raw, expire, step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  tmr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync),
    .sel      (sel),
    .wr       (wr),
    .addr     (addr),
    .wdata    (wdata),
    .expire   (expire),
    .count_rd (count_rd),
    .ctrl     (ctrl),
    .limit    (limit),
    .load_wr  (load_wr),
    .ctrl_wr  (ctrl_wr),
    .raw      (raw),
    .rdata    (rdata)
  );

  tmr_prescaler #(.DIV_A_LOG(DIV_A_LOG), .DIV_B_LOG(DIV_B_LOG)) u_pre (
    .clk     (clk),
    .rst_n   (rst_sync),
    .tick_en (tick_en),
    .run     (ctrl.run),
    .psel    (ctrl.psel),
    .restart (ctrl_wr),
    .step    (step)
  );

  tmr_counter #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync),
    .step     (step),
    .load_wr  (load_wr),
    .load_val (wdata),
    .limit    (limit),
    .periodic (ctrl.periodic),
    .wide     (ctrl.wide),
    .once     (ctrl.once),
    .count_rd (count_rd),
    .expire   (expire)
  );

  assign irq = raw & ctrl.ie;
endmodule

// File: tb/tmr_down_counter_tb.sv
module tmr_down_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0, tick_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  tmr_down_counter u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick_en(tick_en), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=0x%08h exp=0x%08h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic t_reset();
    rd_chk("R1 ctrl", 3'd2, 32'h20);
    rd_chk("R1 load", 3'd0, 32'h0);
    rd_chk("R1 value", 3'd1, 32'h0);
    rd_chk("R1 raw", 3'd4, 32'h0);
    rd_chk("R1 masked", 3'd5, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_regmap();
    bus_wr(3'd2, 32'h22);
    bus_wr(3'd0, 32'h1234_5678);
    rd_chk("R3 load readback", 3'd0, 32'h1234_5678);
    rd_chk("R3 value loaded", 3'd1, 32'h1234_5678);
    rd_chk("R2 bgload readback", 3'd6, 32'h1234_5678);
    bus_wr(3'd1, 32'h0000_AAAA);
    rd_chk("R2 value write ignored", 3'd1, 32'h1234_5678);
    bus_wr(3'd7, 32'hFFFF_FFFF);
    rd_chk("R2 spare write ctrl", 3'd2, 32'h22);
    rd_chk("R2 spare write load", 3'd0, 32'h1234_5678);
    rd_chk("R2 spare read", 3'd7, 32'h0);
    ticks(5);
    rd_chk("R4 stopped no count", 3'd1, 32'h1234_5678);
  endtask

  task automatic t_periodic();
    bus_wr(3'd2, 32'hE2);
    bus_wr(3'd0, 32'd5);
    ticks(4);
    rd_chk("R4 count 5-4", 3'd1, 32'd1);
    rd_chk("R6 raw before expiry", 3'd4, 32'd0);
    ticks(1);
    rd_chk("R6 count at zero", 3'd1, 32'd0);
    rd_chk("R6 raw set", 3'd4, 32'd1);
    rd_chk("R10 masked set", 3'd5, 32'd1);
    check("R10 irq high", {31'd0, irq}, 32'd1);
    ticks(1);
    rd_chk("R6 periodic reload", 3'd1, 32'd5);
    bus_wr(3'd3, 32'd0);
    rd_chk("R11 raw cleared", 3'd4, 32'd0);
    check("R11 irq low", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_bgload();
    bus_wr(3'd0, 32'd6);
    ticks(3);
    bus_wr(3'd6, 32'd9);
    rd_chk("R3 bgload keeps count", 3'd1, 32'd3);
    rd_chk("R3 bgload stored", 3'd0, 32'd9);
    ticks(3);
    rd_chk("R6 bg run to zero", 3'd1, 32'd0);
    ticks(1);
    rd_chk("R6 reload new limit", 3'd1, 32'd9);
    bus_wr(3'd3, 32'd0);
  endtask

  task automatic t_free();
    bus_wr(3'd2, 32'hA0);
    bus_wr(3'd0, 32'd2);
    ticks(2);
    rd_chk("R7 narrow expire raw", 3'd4, 32'd1);
    ticks(1);
    rd_chk("R7 narrow free reload", 3'd1, 32'h0000_FFFF);
    bus_wr(3'd3, 32'd0);
    bus_wr(3'd2, 32'hA2);
    bus_wr(3'd0, 32'd2);
    ticks(3);
    rd_chk("R7 wide free reload", 3'd1, 32'hFFFF_FFFF);
    bus_wr(3'd3, 32'd0);
  endtask

  task automatic t_narrow();
    bus_wr(3'd2, 32'hE0);
    bus_wr(3'd0, 32'h0007_0003);
    rd_chk("R8 zero-extended", 3'd1, 32'd3);
    ticks(3);
    rd_chk("R8 low bits expire", 3'd4, 32'd1);
    rd_chk("R8 at zero", 3'd1, 32'd0);
    ticks(1);
    rd_chk("R8 reload low bits", 3'd1, 32'd3);
    bus_wr(3'd3, 32'd0);
  endtask

  task automatic t_prescale();
    bus_wr(3'd2, 32'hE2);
    bus_wr(3'd0, 32'd10);
    bus_wr(3'd2, 32'hE6);
    ticks(15);
    rd_chk("R5 div16 no step", 3'd1, 32'd10);
    ticks(1);
    rd_chk("R5 div16 step", 3'd1, 32'd9);
    bus_wr(3'd2, 32'hEA);
    ticks(255);
    rd_chk("R5 div256 no step", 3'd1, 32'd9);
    ticks(1);
    rd_chk("R5 div256 step", 3'd1, 32'd8);
    bus_wr(3'd2, 32'hEE);
    ticks(1);
    rd_chk("R5 code11 every tick", 3'd1, 32'd7);
    bus_wr(3'd2, 32'hE6);
    ticks(10);
    bus_wr(3'd2, 32'hE6);
    ticks(15);
    rd_chk("R12 phase restarted", 3'd1, 32'd7);
    ticks(1);
    rd_chk("R12 step after 16", 3'd1, 32'd6);
  endtask

  task automatic t_oneshot();
    bus_wr(3'd2, 32'hE3);
    bus_wr(3'd0, 32'd2);
    ticks(2);
    rd_chk("R9 expire raw", 3'd4, 32'd1);
    ticks(5);
    rd_chk("R9 parked at zero", 3'd1, 32'd0);
    bus_wr(3'd3, 32'd0);
    bus_wr(3'd0, 32'd3);
    ticks(1);
    rd_chk("R9 restart after load", 3'd1, 32'd2);
  endtask

  task automatic t_mask();
    bus_wr(3'd2, 32'hC2);
    bus_wr(3'd0, 32'd1);
    ticks(1);
    rd_chk("R10 raw set", 3'd4, 32'd1);
    rd_chk("R10 masked zero", 3'd5, 32'd0);
    check("R10 irq masked", {31'd0, irq}, 32'd0);
    bus_wr(3'd2, 32'hE2);
    check("R10 irq unmasked", {31'd0, irq}, 32'd1);
    rd_chk("R10 masked one", 3'd5, 32'd1);
    bus_wr(3'd3, 32'd0);
  endtask

  task automatic t_setwins();
    bus_wr(3'd2, 32'hE2);
    bus_wr(3'd0, 32'd1);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = 3'd3; wdata = '0; tick_en = 1'b1;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; tick_en = 1'b0;
    rd_chk("R11 set beats clear", 3'd4, 32'd1);
    bus_wr(3'd3, 32'd0);
    rd_chk("R11 later clear", 3'd4, 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regmap();
    t_periodic();
    t_bgload();
    t_free();
    t_narrow();
    t_prescale();
    t_oneshot();
    t_mask();
    t_setwins();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule